// File: doc/BRIEF.md
# Pixel Result Capture with Range Classification

This block sits behind a pipelined 14-bit imaging converter. It takes the straight-binary result word and the converter's out-of-range flag when the data-valid strobe rises. It labels each result with the index of the pixel the result belongs to and sorts it into one of three classes: in range, overrange or underrange. The converter delivers each result four conversions after the sample was taken, so the block counts conversion starts to recover the pixel index. It drops the results that arrive while the pipeline is still filling.

Two saturating counters record how many accepted results were overrange and how many were underrange. A synchronous clear input zeroes both counters. A synchronous restart input begins a new frame: it clears the conversion count and starts the pipeline fill again. All outputs are registered.

Top module: `pixel_capture`

## Requirements
- R1: While reset is held, and in the first cycle after it, `res_vld_o`, `res_code_o`, `res_pix_o`, `res_cls_o`, `ovr_cnt_o` and `und_cnt_o` are all zero.
- R2: A result is accepted only on a low-to-high transition of `dv_i` seen at a clock edge. The registered outputs change after that same edge. `res_vld_o` is high for exactly one cycle, even when `dv_i` stays high for longer.
- R3: The class encoding on `res_cls_o` is 2'b00 for in range, 2'b01 for overrange and 2'b10 for underrange. When `oor_i` is 0 the result is in range whatever bit 13 (the MSB) of `code_i` is, and `res_code_o` equals `code_i`.
- R4: When `oor_i` is 1 and bit 13 of `code_i` is 1, the class is overrange and `res_code_o` is all ones (14'h3FFF).
- R5: When `oor_i` is 1 and bit 13 of `code_i` is 0, the class is underrange and `res_code_o` is all zeros.
- R6: Let S be the number of rising edges of `start_i` counted since reset or restart. An accepted result carries the pixel index `res_pix_o` = S - 1 - LAT, where LAT is 4 by default.
- R7: A `dv_i` edge that arrives while S is at most LAT is discarded. `res_vld_o` stays low, the other outputs keep their values, and neither counter moves.
- R8: When a `start_i` edge and a `dv_i` edge land on the same clock edge, the result is judged against the value of S from before that start is counted.
- R9: `ovr_cnt_o` and `und_cnt_o` (CNT_W bits, 16 by default) each add one for every accepted result of their own class.
- R10: Each counter stops at its all-ones value and holds it.
- R11: `clr_cnt_i` zeroes both counters at the next clock edge. If a clear and a counting event fall on the same edge, the clear wins.
- R12: `restart_i` sets S to zero at the next edge. A `start_i` edge in the same cycle is ignored, and a `dv_i` edge in the same cycle is discarded.
- R13: The pixel index is taken modulo 2^IDX_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion start; each rising edge counts one conversion |
| dv_i | input | 1 | Data-valid strobe; its rising edge captures a result |
| code_i | input | 14 | Straight-binary result from the converter |
| oor_i | input | 1 | Out-of-range flag, aligned with `code_i` |
| restart_i | input | 1 | Start a new frame: clear the start count and pipeline fill |
| clr_cnt_i | input | 1 | Synchronous clear of both range counters |
| res_vld_o | output | 1 | One-cycle pulse when an accepted result appears |
| res_code_o | output | 14 | Captured code, clamped on range violations |
| res_pix_o | output | IDX_W | Pixel index of the captured result |
| res_cls_o | output | 2 | Range class (00 in, 01 over, 10 under) |
| ovr_cnt_o | output | CNT_W | Saturating count of overrange results |
| und_cnt_o | output | CNT_W | Saturating count of underrange results |

## Verification
A conversion start and a data-valid edge can land on the same clock edge. In that case the pixel index and the pipeline-fill decision must use the start count from before the edge. The bench provokes this on a fixed subset of iterations during the main sweep and compares the index against a model that updates the count after it judges the result. The counter clear can also coincide with an overrange event. The bench drives both in one cycle and expects a zero count next to a valid result. A restart combined with a start edge, and a restart combined with a data-valid edge, are checked the same way.

// File: rtl/pixel_capture_pkg.sv
package pixel_capture_pkg;

    localparam int CODE_W = 14;

    typedef enum logic [1:0] {
        RC_IN    = 2'b00,
        RC_OVER  = 2'b01,
        RC_UNDER = 2'b10
    } range_cls_t;

    typedef struct packed {
        range_cls_t          cls;
        logic [CODE_W-1:0]   code;
    } capt_word_t;

    // The out-of-range flag selects the class; the MSB tells which side.
    function automatic range_cls_t classify(input logic oor, input logic msb);
        if (!oor)
            return RC_IN;
        else if (msb)
            return RC_OVER;
        else
            return RC_UNDER;
    endfunction

endpackage

// File: rtl/rise_detect.sv
module rise_detect (
    input  logic clk,
    input  logic rst,
    input  logic level_i,
    output logic rise_o
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst)
            level_q <= 1'b0;
        else
            level_q <= level_i;
    end

    assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/conv_tracker.sv
module conv_tracker #(
    parameter int IDX_W = 16,
    parameter int LAT   = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic             start_rise_i,
    input  logic             dv_rise_i,
    output logic             take_o,
    output logic [IDX_W-1:0] pix_o
);
    localparam int          FILL_W   = $clog2(LAT + 2);
    localparam logic [FILL_W-1:0] FILL_TOP = FILL_W'(LAT + 1);
    localparam logic [IDX_W-1:0]  BACK     = IDX_W'(LAT + 1);

    logic [IDX_W-1:0]  starts_q;
    logic [FILL_W-1:0] fill_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            starts_q <= '0;
            fill_q   <= '0;
        end else if (start_rise_i) begin
            starts_q <= starts_q + 1'b1;
            if (fill_q != FILL_TOP)
                fill_q <= fill_q + 1'b1;
        end
    end

    // Judged against the count before any start on this same edge.
    assign take_o = dv_rise_i && !restart_i && (fill_q == FILL_TOP);
    assign pix_o  = starts_q - BACK;
endmodule

// File: rtl/range_decoder.sv
module range_decoder
    import pixel_capture_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic              oor_i,
    output capt_word_t        word_o
);
    range_cls_t cls;

    always_comb begin
        cls = classify(oor_i, code_i[CODE_W-1]);
        word_o.cls = cls;
        unique case (cls)
            RC_OVER:  word_o.code = '1;
            RC_UNDER: word_o.code = '0;
            default:  word_o.code = code_i;
        endcase
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_o <= '0;
        else if (inc_i && (cnt_o != '1))
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/pixel_capture.sv
module pixel_capture
    import pixel_capture_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int CNT_W = 16,
    parameter int LAT   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              dv_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              oor_i,
    input  logic              restart_i,
    input  logic              clr_cnt_i,
    output logic              res_vld_o,
    output logic [CODE_W-1:0] res_code_o,
    output logic [IDX_W-1:0]  res_pix_o,
    output logic [1:0]        res_cls_o,
    output logic [CNT_W-1:0]  ovr_cnt_o,
    output logic [CNT_W-1:0]  und_cnt_o
);
    localparam int NUM_CNT = 2;

    logic             start_rise;
    logic             dv_rise;
    logic             take;
    logic [IDX_W-1:0] pix_now;
    capt_word_t       word_now;
    capt_word_t       word_q;
    logic [CNT_W-1:0] cnt_val [NUM_CNT];

    rise_detect u_start_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (start_i),
        .rise_o  (start_rise)
    );

    rise_detect u_dv_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (dv_i),
        .rise_o  (dv_rise)
    );

    conv_tracker #(.IDX_W(IDX_W), .LAT(LAT)) u_track (
        .clk          (clk),
        .rst          (rst),
        .restart_i    (restart_i),
        .start_rise_i (start_rise),
        .dv_rise_i    (dv_rise),
        .take_o       (take),
        .pix_o        (pix_now)
    );

    range_decoder u_dec (
        .code_i (code_i),
        .oor_i  (oor_i),
        .word_o (word_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_vld_o <= 1'b0;
            word_q    <= '{cls: RC_IN, code: '0};
            res_pix_o <= '0;
        end else begin
            res_vld_o <= take;
            if (take) begin
                word_q    <= word_now;
                res_pix_o <= pix_now;
            end
        end
    end

    assign res_code_o = word_q.code;
    assign res_cls_o  = word_q.cls;

    // Index 0 counts overrange, index 1 counts underrange.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        localparam range_cls_t WATCH = (g == 0) ? RC_OVER : RC_UNDER;
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr_i (clr_cnt_i),
            .inc_i (take && (word_now.cls == WATCH)),
            .cnt_o (cnt_val[g])
        );
    end

    assign ovr_cnt_o = cnt_val[0];
    assign und_cnt_o = cnt_val[1];
endmodule

// File: rtl/pixel_capture_chk.sv
module pixel_capture_chk
    import pixel_capture_pkg::*;
#(
    parameter int IDX_W = 16,
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [CODE_W-1:0] code_i,
    input logic              oor_i,
    input logic              restart_i,
    input logic              clr_cnt_i,
    input logic              dv_rise,
    input logic              res_vld_o,
    input logic [CODE_W-1:0] res_code_o,
    input logic [1:0]        res_cls_o,
    input logic [CNT_W-1:0]  ovr_cnt_o,
    input logic [CNT_W-1:0]  und_cnt_o
);
    p_vld_from_edge_r2: assert property (@(posedge clk) disable iff (rst)
        res_vld_o |-> $past(dv_rise));

    p_in_range_r3: assert property (@(posedge clk) disable iff (rst)
        (res_vld_o && !$past(oor_i)) |-> (res_cls_o == 2'b00 && res_code_o == $past(code_i)));

    p_over_clamp_r4: assert property (@(posedge clk) disable iff (rst)
        (res_vld_o && $past(oor_i) && $past(code_i[CODE_W-1]))
        |-> (res_cls_o == 2'b01 && res_code_o == '1));

    p_under_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        (res_vld_o && $past(oor_i) && !$past(code_i[CODE_W-1]))
        |-> (res_cls_o == 2'b10 && res_code_o == '0));

    p_ovr_no_drop_r9: assert property (@(posedge clk) disable iff (rst)
        !clr_cnt_i |=> ovr_cnt_o >= $past(ovr_cnt_o));

    p_und_no_drop_r9: assert property (@(posedge clk) disable iff (rst)
        !clr_cnt_i |=> und_cnt_o >= $past(und_cnt_o));

    p_ovr_sat_r10: assert property (@(posedge clk) disable iff (rst)
        (ovr_cnt_o == '1 && !clr_cnt_i) |=> ovr_cnt_o == '1);

    p_und_sat_r10: assert property (@(posedge clk) disable iff (rst)
        (und_cnt_o == '1 && !clr_cnt_i) |=> und_cnt_o == '1);

    p_clear_wins_r11: assert property (@(posedge clk) disable iff (rst)
        clr_cnt_i |=> (ovr_cnt_o == '0 && und_cnt_o == '0));

    p_restart_drop_r12: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> !res_vld_o);
endmodule

bind pixel_capture pixel_capture_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .code_i     (code_i),
    .oor_i      (oor_i),
    .restart_i  (restart_i),
    .clr_cnt_i  (clr_cnt_i),
    .dv_rise    (dv_rise),
    .res_vld_o  (res_vld_o),
    .res_code_o (res_code_o),
    .res_cls_o  (res_cls_o),
    .ovr_cnt_o  (ovr_cnt_o),
    .und_cnt_o  (und_cnt_o)
);

// File: tb/tb_pixel_capture.sv
`timescale 1ns/1ps
module tb_pixel_capture;
    localparam int IDX_W = 5;
    localparam int CNT_W = 6;
    localparam int LAT   = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              dv_i = 1'b0;
    logic [13:0]       code_i = '0;
    logic              oor_i = 1'b0;
    logic              restart_i = 1'b0;
    logic              clr_cnt_i = 1'b0;
    logic              res_vld_o;
    logic [13:0]       res_code_o;
    logic [IDX_W-1:0]  res_pix_o;
    logic [1:0]        res_cls_o;
    logic [CNT_W-1:0]  ovr_cnt_o;
    logic [CNT_W-1:0]  und_cnt_o;

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    int   s_cnt = 0;
    int   m_ovr = 0;
    int   m_und = 0;
    logic        e_vld = 1'b0;
    logic [13:0] e_code = '0;
    logic [IDX_W-1:0] e_pix = '0;
    logic [1:0]  e_cls = 2'b00;

    always #2.5 clk = ~clk;

    pixel_capture #(.IDX_W(IDX_W), .CNT_W(CNT_W), .LAT(LAT)) dut (
        .clk(clk), .rst(rst), .start_i(start_i), .dv_i(dv_i), .code_i(code_i),
        .oor_i(oor_i), .restart_i(restart_i), .clr_cnt_i(clr_cnt_i),
        .res_vld_o(res_vld_o), .res_code_o(res_code_o), .res_pix_o(res_pix_o),
        .res_cls_o(res_cls_o), .ovr_cnt_o(ovr_cnt_o), .und_cnt_o(und_cnt_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check(req, "vld",  int'(res_vld_o),  int'(e_vld));
        check(req, "code", int'(res_code_o), int'(e_code));
        check(req, "pix",  int'(res_pix_o),  int'(e_pix));
        check(req, "cls",  int'(res_cls_o),  int'(e_cls));
        check(req, "ovr",  int'(ovr_cnt_o),  m_ovr);
        check(req, "und",  int'(und_cnt_o),  m_und);
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        s_cnt++;
    endtask

    // One data-valid edge with optional same-cycle start, restart and clear.
    task automatic dv_cycle(input logic [13:0] c, input logic o, input bit w_start,
                            input bit w_restart, input bit w_clr, input string req);
        bit take;
        logic [1:0] cls;
        @(negedge clk);
        code_i = c; oor_i = o; dv_i = 1'b1;
        start_i = w_start; restart_i = w_restart; clr_cnt_i = w_clr;
        @(negedge clk);
        dv_i = 1'b0; start_i = 1'b0; restart_i = 1'b0; clr_cnt_i = 1'b0;
        take = !w_restart && (s_cnt >= LAT + 1);
        cls  = !o ? 2'b00 : (c[13] ? 2'b01 : 2'b10);
        e_vld = take;
        if (take) begin
            e_cls  = cls;
            e_code = (cls == 2'b01) ? 14'h3FFF : ((cls == 2'b10) ? 14'h0000 : c);
            e_pix  = IDX_W'(s_cnt - 1 - LAT);
        end
        if (w_clr) begin
            m_ovr = 0; m_und = 0;
        end else if (take) begin
            if (cls == 2'b01 && m_ovr < CMAX) m_ovr++;
            if (cls == 2'b10 && m_und < CMAX) m_und++;
        end
        if (w_restart) s_cnt = 0;
        else if (w_start) s_cnt++;
        check_all(req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        // R1: reset state while held
        @(negedge clk);
        check_all("R1");
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // R7: pipeline filling, overrange results must be dropped
        e_code = '0;
        for (int k = 0; k < LAT; k++) begin
            pulse_start();
            dv_cycle(14'h3FFF, 1'b1, 1'b0, 1'b0, 1'b0, "R7");
        end

        // Main sweep R3 R4 R5 R6 R8 R9 R10 R13
        for (int i = 0; i < 320; i++) begin
            logic [13:0] c;
            logic        o;
            bit          same;
            c = 14'((i * 2731 + 17) & 14'h1FFF);
            case (i % 4)
                0: begin o = 1'b0; c[13] = 1'b0; end
                1: begin o = 1'b0; c[13] = 1'b1; end
                2: begin o = 1'b1; c[13] = 1'b1; end
                default: begin o = 1'b1; c[13] = 1'b0; end
            endcase
            same = (i % 7 == 3);
            if (!same) pulse_start();
            dv_cycle(c, o, same, 1'b0, 1'b0, same ? "R8" : "R6");
        end
        check("R10", "ovr saturated", int'(ovr_cnt_o), CMAX);
        check("R10", "und saturated", int'(und_cnt_o), CMAX);

        // R2: dv held high gives one pulse only
        pulse_start();
        @(negedge clk); code_i = 14'h0123; oor_i = 1'b0; dv_i = 1'b1;
        @(negedge clk);
        check("R2", "first vld", int'(res_vld_o), 1);
        check("R2", "code", int'(res_code_o), 14'h0123);
        @(negedge clk);
        check("R2", "held vld", int'(res_vld_o), 0);
        @(negedge clk);
        check("R2", "held vld", int'(res_vld_o), 0);
        dv_i = 1'b0;
        e_vld = 1'b0; e_code = 14'h0123; e_cls = 2'b00; e_pix = IDX_W'(s_cnt - 1 - LAT);
        @(negedge clk);
        check_all("R2");

        // R11: clear alone, then clear with an overrange event
        @(negedge clk); clr_cnt_i = 1'b1;
        @(negedge clk); clr_cnt_i = 1'b0;
        m_ovr = 0; m_und = 0;
        check_all("R11");
        pulse_start();
        dv_cycle(14'h2000, 1'b1, 1'b0, 1'b0, 1'b1, "R11");
        dv_cycle(14'h0001, 1'b1, 1'b0, 1'b0, 1'b0, "R9");

        // R12: restart with dv, restart with start, refill
        dv_cycle(14'h2222, 1'b0, 1'b0, 1'b1, 1'b0, "R12");
        @(negedge clk); restart_i = 1'b1; start_i = 1'b1;
        @(negedge clk); restart_i = 1'b0; start_i = 1'b0;
        s_cnt = 0;
        for (int k = 0; k < LAT; k++) pulse_start();
        dv_cycle(14'h0055, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        pulse_start();
        dv_cycle(14'h0066, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        check("R12", "pix after refill", int'(res_pix_o), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule